// File: doc/BRIEF.md
# Synchronous Burst Read Sequencer

This block runs the clocked burst read path of a NOR-style flash interface. Two configuration words set its behaviour: a main word and an extension word. A start address is captured on a clock edge where the address strobe and chip enable are both high. The sequencer then waits a programmed number of clock edges before presenting the first data word. After that it advances the word address once per clock. It either wraps inside an aligned window of the burst length or counts straight upward. A ready output tells the host when data is valid. Its polarity can be set, and it can either lead the data by one cycle or arrive together with it.

The storage behind the sequencer is a behavioural word array. It holds no state: each word is a fixed function of its address. When the main word selects asynchronous operation, the burst machine stays idle and ignores the strobe. Dropping chip enable ends any burst at once. A strobe that arrives during a burst starts a fresh latency count from the new address.

The control is a four-state machine:

- **IDLE**: no burst. It moves to WAIT on a start, meaning strobe, chip enable and synchronous mode all on one edge.
- **WAIT**: counts latency. It moves to DATA when the count is spent, or restarts WAIT on a new start.
- **DATA**: one word per clock. It moves to DONE after the last word of a fixed-length burst, or back to WAIT on a new start.
- **DONE**: the fixed-length burst is finished and ready is inactive. It moves to WAIT on a new start.

Any state falls back to IDLE when chip enable is low.

Top module: `burst_rd_seq`

## Requirements
- R1: After reset, or with chip enable low, the sequencer is idle. `data_valid` is 0 and `rdy_out` is at its inactive level, which is the inverse of `cfg_main[10]`.
- R2: The latency code is the 4-bit value {`cfg_ext[0]`, `cfg_main[13:11]`}. Codes 0000 to 0101 give N = 2 to 7, and 1000 and 1001 give N = 8 and 9. Call the latching edge edge 0. The first word is valid on edge N, so `data_valid` rises just after edge N-1.
- R3: `cfg_main[2:0]` sets the burst length: 010 gives 8 words, 011 gives 16 and 100 gives 32. Any other value gives a continuous burst. A fixed burst delivers exactly that many words. After them `data_valid` falls and ready goes inactive until the next start.
- R4: With `cfg_main[3]` = 1 and a fixed length L, the address steps through the aligned L-word window that holds the start address. It wraps from the top of the window to its base.
- R5: With `cfg_main[3]` = 0, or in continuous mode, the address increases by one per data word with no wrap. A continuous burst runs until chip enable goes low.
- R6: `cfg_main[10]` = 1 makes ready active high, and 0 makes it active low. Ready is at its active level in every data cycle.
- R7: With `cfg_main[8]` = 0, ready turns active one cycle before the first word. With `cfg_main[8]` = 1, it turns active in the same cycle as the first word.
- R8: With `cfg_main[15]` = 1 (asynchronous mode), the strobe starts no burst. `data_valid` stays 0 and ready stays inactive.
- R9: Chip enable low aborts any burst on the next edge and returns the block to IDLE. A strobe sampled while chip enable is low starts nothing.
- R10: A start during WAIT or DATA reloads the address and the latency count. The new first word follows the new start after the full latency.
- R11: During data cycles, `word_addr` is the current word address. `data_out` is `word_addr[15:0]` XOR 16'hC3A5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_main | input | 16 | Main configuration word |
| cfg_ext | input | 16 | Extension configuration word; bit 0 is the top latency bit |
| chip_en | input | 1 | Chip enable, active high |
| addr_strobe | input | 1 | Address valid strobe |
| start_addr | input | 24 | Burst start word address |
| rdy_out | output | 1 | Ready indication with programmed polarity and timing |
| data_valid | output | 1 | High in cycles carrying a data word |
| data_out | output | 16 | Data word |
| word_addr | output | 24 | Current word address |

## Verification
The bench runs bursts at the shortest latency (2), the longest (9) and an odd middle value. The longest latency uses the split top code bit. A design that ignored the extension bit, or read the code as contiguous, would present data several edges early. Wrapped bursts start near the top of their window. A mask taken from the wrong length, or a plain increment, would send the address across the window edge. A continuous burst crosses a 64K word boundary. The bench also aborts mid-burst, restarts with a strobe between data words, and strobes in asynchronous mode and with chip enable low. A design that kept counting after chip enable fell, missed the restart, or ignored the mode bit would emit words the scoreboard never queued.

// File: rtl/bseq_pkg.sv
package bseq_pkg;
    localparam int LEN_W = 6;
    localparam int LAT_W = 3;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_DATA = 2'd2,
        ST_DONE = 2'd3
    } bseq_state_t;

    typedef struct packed {
        logic             async_mode;
        logic [LAT_W-1:0] lat_m2;      // latency minus two
        logic             rdy_high;
        logic             rdy_aligned;
        logic             wrap_en;
        logic             cont;
        logic [LEN_W-1:0] burst_len;
    } bseq_cfg_t;
endpackage

// File: rtl/bseq_cfg_decode.sv
module bseq_cfg_decode
    import bseq_pkg::*;
#(
    parameter int CFG_W = 16
) (
    input  logic [CFG_W-1:0] cfg_main,
    input  logic [CFG_W-1:0] cfg_ext,
    output bseq_cfg_t        dec
);
    logic [3:0] lat_code;
    logic       cfg_unused;

    assign lat_code   = {cfg_ext[0], cfg_main[13:11]};
    assign cfg_unused = ^{cfg_main[14], cfg_main[9], cfg_main[7:4], cfg_ext[CFG_W-1:1]};

    always_comb begin
        dec             = '0;
        dec.async_mode  = cfg_main[15];
        dec.rdy_high    = cfg_main[10];
        dec.rdy_aligned = cfg_main[8];
        dec.wrap_en     = cfg_main[3];
        // split code: top bit selects the 8/9 pair
        dec.lat_m2      = lat_code[3] ? {2'b11, lat_code[0]} : lat_code[2:0];
        case (cfg_main[2:0])
            3'b010:  begin dec.cont = 1'b0; dec.burst_len = LEN_W'(8);  end
            3'b011:  begin dec.cont = 1'b0; dec.burst_len = LEN_W'(16); end
            3'b100:  begin dec.cont = 1'b0; dec.burst_len = LEN_W'(32); end
            default: begin dec.cont = 1'b1; dec.burst_len = '0;         end
        endcase
    end
endmodule

// File: rtl/bseq_addr_gen.sv
module bseq_addr_gen #(
    parameter int ADDR_W = 24,
    parameter int LEN_W  = 6
) (
    input  logic [ADDR_W-1:0] cur,
    input  logic              wrap_en,
    input  logic              cont,
    input  logic [LEN_W-1:0]  burst_len,
    output logic [ADDR_W-1:0] nxt
);
    logic [ADDR_W-1:0] inc;
    logic [ADDR_W-1:0] win_mask;

    assign inc      = cur + ADDR_W'(1);
    assign win_mask = ADDR_W'(burst_len) - ADDR_W'(1);

    always_comb begin
        if (wrap_en && !cont)
            nxt = (cur & ~win_mask) | (inc & win_mask);
        else
            nxt = inc;
    end
endmodule

// File: rtl/bseq_word_array.sv
module bseq_word_array #(
    parameter int              ADDR_W  = 24,
    parameter int              DATA_W  = 16,
    parameter logic [DATA_W-1:0] PATTERN = 'hC3A5
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] word
);
    logic addr_unused;

    assign addr_unused = ^addr[ADDR_W-1:DATA_W];
    assign word        = addr[DATA_W-1:0] ^ PATTERN;
endmodule

// File: rtl/burst_rd_seq.sv
module burst_rd_seq
    import bseq_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 16,
    parameter int CFG_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CFG_W-1:0]  cfg_main,
    input  logic [CFG_W-1:0]  cfg_ext,
    input  logic              chip_en,
    input  logic              addr_strobe,
    input  logic [ADDR_W-1:0] start_addr,
    output logic              rdy_out,
    output logic              data_valid,
    output logic [DATA_W-1:0] data_out,
    output logic [ADDR_W-1:0] word_addr
);
    bseq_state_t       state, nxt_state;
    bseq_cfg_t         live_cfg, lat_cfg;
    logic [LAT_W-1:0]  wait_cnt;
    logic [LEN_W-1:0]  beat_cnt;
    logic [ADDR_W-1:0] cur_addr, nxt_addr;
    logic [DATA_W-1:0] arr_word;
    logic              start;
    logic              last_beat;
    logic              rdy_act;

    bseq_cfg_decode #(.CFG_W(CFG_W)) u_dec (
        .cfg_main (cfg_main),
        .cfg_ext  (cfg_ext),
        .dec      (live_cfg)
    );

    bseq_addr_gen #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_agen (
        .cur       (cur_addr),
        .wrap_en   (lat_cfg.wrap_en),
        .cont      (lat_cfg.cont),
        .burst_len (lat_cfg.burst_len),
        .nxt       (nxt_addr)
    );

    bseq_word_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arr (
        .addr (cur_addr),
        .word (arr_word)
    );

    assign start     = chip_en && addr_strobe && !live_cfg.async_mode;
    assign last_beat = !lat_cfg.cont && (beat_cnt == lat_cfg.burst_len - LEN_W'(1));

    // next state
    always_comb begin
        nxt_state = state;
        unique case (state)
            ST_IDLE: if (start) nxt_state = ST_WAIT;
            ST_WAIT: begin
                if (start)              nxt_state = ST_WAIT;
                else if (wait_cnt == '0) nxt_state = ST_DATA;
            end
            ST_DATA: begin
                if (start)          nxt_state = ST_WAIT;
                else if (last_beat) nxt_state = ST_DONE;
            end
            ST_DONE: if (start) nxt_state = ST_WAIT;
        endcase
        if (!chip_en) nxt_state = ST_IDLE;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt_state;
    end

    // address, counters and latched settings
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_addr <= '0;
            wait_cnt <= '0;
            beat_cnt <= '0;
            lat_cfg  <= '0;
        end else if (start) begin
            cur_addr <= start_addr;
            wait_cnt <= live_cfg.lat_m2;
            beat_cnt <= '0;
            lat_cfg  <= live_cfg;
        end else if (state == ST_WAIT && wait_cnt != '0) begin
            wait_cnt <= wait_cnt - LAT_W'(1);
        end else if (state == ST_DATA && chip_en) begin
            cur_addr <= nxt_addr;
            beat_cnt <= beat_cnt + LEN_W'(1);
        end
    end

    // outputs
    always_comb begin
        rdy_act = 1'b0;
        unique case (state)
            ST_IDLE: rdy_act = 1'b0;
            ST_WAIT: rdy_act = (wait_cnt == '0) && !live_cfg.rdy_aligned;
            ST_DATA: rdy_act = 1'b1;
            ST_DONE: rdy_act = 1'b0;
        endcase
        rdy_out    = live_cfg.rdy_high ? rdy_act : !rdy_act;
        data_valid = (state == ST_DATA);
        data_out   = (state == ST_DATA) ? arr_word : '0;
        word_addr  = cur_addr;
    end
endmodule

// File: rtl/bseq_chk.sv
module bseq_chk
    import bseq_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              chip_en,
    input logic              cfg_async,
    input logic              cfg_rdy_high,
    input logic              cfg_aligned,
    input logic              data_valid,
    input logic              rdy_out,
    input logic [ADDR_W-1:0] word_addr,
    input bseq_state_t       state,
    input logic              lat_wrap,
    input logic              lat_cont,
    input logic [LEN_W-1:0]  lat_len
);
    logic [LEN_W-1:0]  beat_seen;
    logic [ADDR_W-1:0] win_mask;

    assign win_mask = ADDR_W'(lat_len) - ADDR_W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          beat_seen <= '0;
        else if (!data_valid) beat_seen <= '0;
        else if (beat_seen != '1) beat_seen <= beat_seen + LEN_W'(1);
    end

    AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !chip_en |=> (!data_valid && rdy_out == !cfg_rdy_high)); // R9

    AST_EARLY_READY: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(data_valid) && !$past(cfg_aligned)) |-> ($past(rdy_out) == $past(cfg_rdy_high))); // R7

    AST_NOT_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(data_valid) && $past(cfg_aligned)) |-> ($past(rdy_out) != $past(cfg_rdy_high))); // R7

    AST_WRAP_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (data_valid && $past(data_valid) && lat_wrap && !lat_cont)
        |-> ((word_addr & ~win_mask) == ($past(word_addr) & ~win_mask))); // R4

    AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (data_valid && $past(data_valid) && (lat_cont || !lat_wrap))
        |-> (word_addr == $past(word_addr) + ADDR_W'(1))); // R5

    AST_BURST_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (data_valid && !lat_cont) |-> (beat_seen < lat_len)); // R3

    AST_ASYNC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && cfg_async) |=> (state == ST_IDLE)); // R8
endmodule

bind burst_rd_seq bseq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .chip_en      (chip_en),
    .cfg_async    (cfg_main[15]),
    .cfg_rdy_high (cfg_main[10]),
    .cfg_aligned  (cfg_main[8]),
    .data_valid   (data_valid),
    .rdy_out      (rdy_out),
    .word_addr    (word_addr),
    .state        (state),
    .lat_wrap     (lat_cfg.wrap_en),
    .lat_cont     (lat_cfg.cont),
    .lat_len      (lat_cfg.burst_len)
);

// File: tb/tb_burst_rd_seq.sv
module tb_burst_rd_seq;
    localparam int AW = 24;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [15:0]   cfg_main, cfg_ext;
    logic          chip_en, addr_strobe;
    logic [AW-1:0] start_addr;
    logic          rdy_out, data_valid;
    logic [DW-1:0] data_out;
    logic [AW-1:0] word_addr;

    int n_chk = 0;
    int n_fail = 0;

    typedef struct {
        logic [AW-1:0] a;
        string         tag;
    } exp_t;
    exp_t expq[$];

    always #4 clk = ~clk;

    burst_rd_seq dut (
        .clk(clk), .rst_n(rst_n), .cfg_main(cfg_main), .cfg_ext(cfg_ext),
        .chip_en(chip_en), .addr_strobe(addr_strobe), .start_addr(start_addr),
        .rdy_out(rdy_out), .data_valid(data_valid), .data_out(data_out),
        .word_addr(word_addr)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
        end
    endtask

    function automatic logic [15:0] mk0(bit asy, logic [3:0] code, bit pol,
                                        bit aligned, bit wrap, logic [2:0] lenc);
        logic [15:0] v = '0;
        v[15] = asy; v[13:11] = code[2:0]; v[10] = pol;
        v[8] = aligned; v[3] = wrap; v[2:0] = lenc;
        return v;
    endfunction

    function automatic int lat_of(logic [3:0] code);
        if (code[3]) return 8 + int'(code[0]);
        return 2 + int'(code[2:0]);
    endfunction

    function automatic int len_of(logic [2:0] lenc);
        case (lenc)
            3'b010:  return 8;
            3'b011:  return 16;
            3'b100:  return 32;
            default: return 0;
        endcase
    endfunction

    function automatic logic [AW-1:0] exp_addr(logic [AW-1:0] a, int i, int l, bit wrap);
        logic [AW-1:0] m;
        if (l != 0 && wrap) begin
            m = AW'(l - 1);
            return (a & ~m) | ((a + AW'(i)) & m);
        end
        return a + AW'(i);
    endfunction

    // monitor / scoreboard
    always @(negedge clk) begin
        exp_t e;
        if (rst_n && data_valid) begin
            if (expq.size() == 0) begin
                chk(1'b0, "R3", "unexpected data beat", word_addr, 0);
            end else begin
                e = expq.pop_front();
                chk(word_addr == e.a, e.tag, "beat address", word_addr, e.a);
                chk(data_out == (e.a[15:0] ^ 16'hC3A5), "R11", "beat data",
                    data_out, e.a[15:0] ^ 16'hC3A5);
            end
        end
    end

    task automatic run_burst(input logic [AW-1:0] a, input logic [3:0] code,
                             input logic [2:0] lenc, input bit wrap, input bit early,
                             input bit pol, input int drop_after, input string atag);
        int n  = lat_of(code);
        int l  = len_of(lenc);
        int nb = (l != 0) ? l : drop_after;
        @(negedge clk);
        cfg_main = mk0(1'b0, code, pol, !early, wrap, lenc);
        cfg_ext  = {15'b0, code[3]};
        chip_en  = 1'b1;
        @(negedge clk);
        for (int i = 0; i < nb; i++) expq.push_back('{exp_addr(a, i, l, wrap), atag});
        addr_strobe = 1'b1;
        start_addr  = a;
        for (int k = 1; k < n + nb; k++) begin
            @(negedge clk);
            addr_strobe = 1'b0;
            if (k == n - 1) begin
                chk(!data_valid, "R2", "valid before edge N", data_valid, 0);
                chk(rdy_out == (early ? pol : !pol), "R7", "ready before first word",
                    rdy_out, early ? pol : !pol);
            end
            if (k == n) begin
                chk(data_valid, "R2", "first word on edge N", data_valid, 1);
                chk(rdy_out == pol, "R6", "ready level with data", rdy_out, pol);
            end
        end
        if (l == 0) chip_en = 1'b0;
        @(negedge clk);
        chk(!data_valid, (l == 0) ? "R9" : "R3", "valid after end", data_valid, 0);
        chk(rdy_out == !pol, (l == 0) ? "R9" : "R3", "ready after end", rdy_out, !pol);
        chk(expq.size() == 0, "R3", "words missing", expq.size(), 0);
        chip_en = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        bit seen;
        cfg_main    = mk0(1'b0, 4'b0101, 1'b1, 1'b1, 1'b1, 3'b010);
        cfg_ext     = '0;
        chip_en     = 1'b0;
        addr_strobe = 1'b0;
        start_addr  = '0;
        repeat (3) @(negedge clk);
        chk(!data_valid, "R1", "valid in reset", data_valid, 0);
        chk(rdy_out == 1'b0, "R1", "ready in reset", rdy_out, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!data_valid && rdy_out == 1'b0, "R1", "idle after reset", data_valid, 0);

        run_burst(24'h000105, 4'b0101, 3'b010, 1'b1, 1'b0, 1'b1, 0,  "R4");
        run_burst(24'h0000FE, 4'b0000, 3'b011, 1'b1, 1'b1, 1'b1, 0,  "R4");
        run_burst(24'h00003C, 4'b1001, 3'b100, 1'b0, 1'b0, 1'b0, 0,  "R5");
        run_burst(24'h00FFFA, 4'b1000, 3'b000, 1'b1, 1'b1, 1'b1, 40, "R5");
        run_burst(24'h123457, 4'b0011, 3'b010, 1'b0, 1'b1, 1'b0, 0,  "R5");

        // asynchronous mode: strobe ignored (R8)
        @(negedge clk);
        cfg_main = mk0(1'b1, 4'b0001, 1'b1, 1'b1, 1'b1, 3'b010);
        cfg_ext  = '0;
        chip_en  = 1'b1;
        @(negedge clk);
        addr_strobe = 1'b1; start_addr = 24'h000400;
        seen = 1'b0;
        repeat (12) begin
            @(negedge clk);
            addr_strobe = 1'b0;
            if (data_valid || rdy_out) seen = 1'b1;
        end
        chk(!seen, "R8", "activity in async mode", seen, 0);
        chip_en = 1'b0;

        // strobe with chip enable low (R9)
        @(negedge clk);
        cfg_main = mk0(1'b0, 4'b0001, 1'b1, 1'b1, 1'b1, 3'b010);
        addr_strobe = 1'b1; start_addr = 24'h000500;
        seen = 1'b0;
        repeat (12) begin
            @(negedge clk);
            addr_strobe = 1'b0;
            if (data_valid || rdy_out) seen = 1'b1;
        end
        chk(!seen, "R9", "activity with chip enable low", seen, 0);

        // restart during a burst (R10)
        @(negedge clk);
        cfg_main = mk0(1'b0, 4'b0001, 1'b1, 1'b1, 1'b0, 3'b000);
        cfg_ext  = '0;
        chip_en  = 1'b1;
        @(negedge clk);
        for (int i = 0; i < 3; i++) expq.push_back('{24'h000200 + AW'(i), "R10"});
        for (int i = 0; i < 5; i++) expq.push_back('{24'h0007F0 + AW'(i), "R10"});
        addr_strobe = 1'b1; start_addr = 24'h000200;
        for (int k = 1; k <= 12; k++) begin
            @(negedge clk);
            addr_strobe = 1'b0;
            if (k == 5) begin addr_strobe = 1'b1; start_addr = 24'h0007F0; end
            if (k == 6 || k == 7) chk(!data_valid, "R10", "gap after restart", data_valid, 0);
            if (k == 8) chk(data_valid, "R10", "first word after restart", data_valid, 1);
        end
        chip_en = 1'b0;
        @(negedge clk);
        chk(!data_valid, "R9", "abort after restart", data_valid, 0);
        chk(expq.size() == 0, "R10", "words missing after restart", expq.size(), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        chk(1'b0, "R1", "watchdog expired", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule